// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write an external asynchronous static RAM of 131,072 bytes. The RAM has one shared set of eight data lines and active-low select, write-strobe and output-enable controls. The user side offers a simple request/ready handshake. A request carries a 17-bit address, a direction flag and a write byte, and a read returns its byte with a one-cycle valid pulse. On the memory side the controller drives every control line and the address from registers. It presents the data lines as a separate output value, a drive enable and an input value, so that the pad buffer sits outside the block.

Each timing phase is a parameter counted in clock cycles: read access, write-strobe width, output-float wait and post-write address hold. The defaults suit a 10 ns memory grade at a 100 MHz clock. A write always starts with a setup phase in which the chip is selected with its outputs disabled. The controller waits out the memory's output-float time there before it turns on its own drivers. The strobe that follows is the short form allowed while output enable is high. Reads keep select and output enable low for the access time, and the byte is captured on the last cycle of that window.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only at a rising edge where both `req_ready` and `req_valid` are 1. While the controller is busy, `req_ready` is 0 and `req_valid` has no effect: the address and strobes of the running access do not change and no extra access follows.
- R3: A read (`req_write` = 0) holds `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly ACC_CYC cycles, starting in the cycle after acceptance, with `mem_addr` equal to the request address.
- R4: The read byte is sampled from `mem_dq_i` on the last access cycle. In the following cycle `rsp_valid` is 1 for exactly one cycle, `rsp_rdata` holds the byte and `req_ready` is 1 again.
- R5: A write (`req_write` = 1) first holds `mem_cs_n` at 0 with `mem_we_n` and `mem_oe_n` at 1 for TURN_CYC cycles, starting in the cycle after acceptance.
- R6: The write strobe `mem_we_n` is then 0 for exactly WP_CYC cycles. During the strobe `mem_oe_n` is 1, `mem_cs_n` is 0, `mem_dq_oe` is 1 and `mem_dq_o` equals the request's write byte.
- R7: `mem_we_n` and `mem_cs_n` rise, and `mem_dq_oe` falls, at the same clock edge. The address then stays unchanged for REC_CYC more busy cycles with select high, and `req_ready` returns to 1 after them.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It rises only after `mem_oe_n` has been 1 for at least TURN_CYC cycles.
- R9: `mem_addr` changes only while `mem_we_n` is 1. It is stable from acceptance until the end of the access.
- R10: A request presented in the first cycle `req_ready` is back at 1 is accepted at once, so its memory cycle begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse, read byte available |
| rsp_rdata | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Value for the data lines when driven |
| mem_dq_oe | output | 1 | Drive enable for the data lines |
| mem_dq_i | input | DATA_W | Value seen on the data lines |

## Verification
The bench models a memory whose read data stays garbage until the access time has elapsed. A controller that captures one cycle early then returns the wrong byte. The model also stores junk when a strobe occurs with the drivers off, which exposes a driver release that comes before the strobe ends. The timing parameters are all set to different values, so a phase that uses the wrong count, or is one cycle short or long, changes the measured phase lengths. The bench watches every busy cycle for driver/output-enable overlap, address movement and a request poked in mid-access. It sweeps writes and read-back over both ends of the address space, so an aliased or truncated address line reads back the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_WSET   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4
  } ctrl_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int ACC_CYC  = 1,
  parameter int WP_CYC   = 1,
  parameter int TURN_CYC = 1,
  parameter int REC_CYC  = 1,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              req_ready,
  output logic              accept_wr,
  output logic              pulse_start,
  output logic              pulse_end,
  output logic              capture,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

  ctrl_state_t state_q, state_d;
  logic        accept;
  logic        accept_rd;
  logic        wr_done;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign accept_rd = accept && !req_write;
  assign accept_wr = accept && req_write;

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    pulse_start = 1'b0;
    pulse_end   = 1'b0;
    capture     = 1'b0;
    wr_done     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_rd) begin
          state_d  = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = ACC_LD;
        end else if (accept_wr) begin
          state_d  = ST_WSET;
          tmr_load = 1'b1;
          tmr_val  = TURN_LD;
        end
      end
      ST_RD: begin
        if (tmr_done) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSET: begin
        if (tmr_done) begin
          pulse_start = 1'b1;
          state_d     = ST_WPULSE;
          tmr_load    = 1'b1;
          tmr_val     = WP_LD;
        end
      end
      ST_WPULSE: begin
        if (tmr_done) begin
          pulse_end = 1'b1;
          state_d   = ST_WREC;
          tmr_load  = 1'b1;
          tmr_val   = REC_LD;
        end
      end
      ST_WREC: begin
        if (tmr_done) begin
          wr_done = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_ready <= 1'b1;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
    end else begin
      state_q   <= state_d;
      req_ready <= (state_d == ST_IDLE);
      if (accept) begin
        mem_addr <= req_addr;
      end
      if (accept) begin
        mem_cs_n <= 1'b0;
      end else if (capture || pulse_end || wr_done) begin
        mem_cs_n <= 1'b1;
      end
      if (accept_rd) begin
        mem_oe_n <= 1'b0;
      end else if (capture) begin
        mem_oe_n <= 1'b1;
      end
      if (pulse_start) begin
        mem_we_n <= 1'b0;
      end else if (pulse_end) begin
        mem_we_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pulse_start,
  input  logic              pulse_end,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept_wr) begin
        mem_dq_o <= req_wdata;
      end
      if (pulse_start) begin
        mem_dq_oe <= 1'b1;
      end else if (pulse_end) begin
        mem_dq_oe <= 1'b0;
      end
      rsp_valid <= capture;
      if (capture) begin
        rsp_rdata <= mem_dq_i;
      end
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int ACC_CYC  = 1,
  parameter int WP_CYC   = 1,
  parameter int TURN_CYC = 1,
  parameter int REC_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int MAX_PH = max2(max2(ACC_CYC, WP_CYC), max2(TURN_CYC, REC_CYC));
  localparam int CNT_W  = $clog2(MAX_PH + 1) + 1;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             accept_wr;
  logic             pulse_start;
  logic             pulse_end;
  logic             capture;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctrl_fsm #(
    .ADDR_W   (ADDR_W),
    .ACC_CYC  (ACC_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .REC_CYC  (REC_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .req_ready   (req_ready),
    .accept_wr   (accept_wr),
    .pulse_start (pulse_start),
    .pulse_end   (pulse_end),
    .capture     (capture),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n)
  );

  sram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk         (clk),
    .rst         (rst),
    .accept_wr   (accept_wr),
    .req_wdata   (req_wdata),
    .pulse_start (pulse_start),
    .pulse_end   (pulse_end),
    .capture     (capture),
    .mem_dq_i    (mem_dq_i),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe   (mem_dq_oe),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int WP_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [7:0] oe_hi_cnt;
  logic [7:0] we_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      if (!mem_oe_n) oe_hi_cnt <= '0;
      else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (mem_we_n) we_lo_cnt <= '0;
      else if (we_lo_cnt != 8'hFF) we_lo_cnt <= we_lo_cnt + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready)); // R1

  AST_READY_DESELECT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n && req_ready)); // R4

  AST_STROBE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n)); // R6

  AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n); // R6

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == 8'(WP_CYC))); // R6

  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($fell(mem_dq_oe) && $rose(mem_cs_n))); // R7

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R8

  AST_TURN_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(TURN_CYC))); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $stable(mem_addr)); // R9

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .WP_CYC   (WP_CYC),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;

  localparam int AW   = 17;
  localparam int DW   = 8;
  localparam int ACC  = 3;
  localparam int WP   = 4;
  localparam int TURN = 2;
  localparam int REC  = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] mem_dq_o;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_bus_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .WP_CYC(WP),
    .TURN_CYC(TURN), .REC_CYC(REC)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model: low 10 address bits, data valid only after the access time.
  logic [DW-1:0] mem [0:1023];
  int rd_age = 0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n)
      mem[mem_addr[9:0]] <= mem_dq_oe ? mem_dq_o : 8'hA5;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
    else rd_age <= 0;
  end

  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && rd_age >= ACC - 1)
                    ? mem[mem_addr[9:0]] : 8'hEE;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return {a[3:0] ^ {3'b000, a[16]}, ~a[3:0]};
  endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge with req_ready high.
  task automatic run_op(input bit wr, input logic [AW-1:0] a,
                        input logic [7:0] d, input bit poke);
    int busy = 0, cs_lo = 0, we_lo = 0, oe_lo = 0, turn = 0, rec = 0;
    int addr_bad = 0, drv_bad = 0, data_bad = 0, cont = 0, early_rsp = 0;
    int first_cs = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 100) begin
      if (busy == 0) begin
        early_rsp = int'(rsp_valid);
        first_cs  = int'(!mem_cs_n);
      end
      if (mem_addr != a) addr_bad++;
      if (!mem_cs_n) cs_lo++;
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (!mem_cs_n && mem_we_n && mem_oe_n && we_lo == 0) turn++;
      if (mem_cs_n) rec++;
      if (mem_dq_oe != !mem_we_n) drv_bad++;
      if (mem_dq_oe && mem_dq_o != d) data_bad++;
      if (mem_dq_oe && !mem_oe_n) cont++;
      if (poke && busy == 0) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = a ^ 17'h00155;
      end
      if (poke && busy == 1) req_valid = 1'b0;
      busy++;
      @(negedge clk);
    end
    chk("R10 memory cycle starts right after acceptance", first_cs == 1, first_cs, 1);
    chk("R4 no stale valid pulse", early_rsp == 0, early_rsp, 0);
    chk("R9 address stable over access", addr_bad == 0, addr_bad, 0);
    chk("R8 no driver while output enabled", cont == 0, cont, 0);
    if (wr) begin
      chk("R2 R7 write busy length", busy == TURN + WP + REC, busy, TURN + WP + REC);
      chk("R5 setup cycles", turn == TURN, turn, TURN);
      chk("R6 strobe cycles", we_lo == WP, we_lo, WP);
      chk("R6 output enable high in write", oe_lo == 0, oe_lo, 0);
      chk("R6 R7 drive tracks strobe", drv_bad == 0, drv_bad, 0);
      chk("R6 driven byte", data_bad == 0, data_bad, 0);
      chk("R7 recovery cycles", rec == REC, rec, REC);
      chk("R2 no response to write", rsp_valid == 1'b0, int'(rsp_valid), 0);
    end else begin
      chk("R3 read busy length", busy == ACC, busy, ACC);
      chk("R3 select cycles", cs_lo == ACC, cs_lo, ACC);
      chk("R3 output enable cycles", oe_lo == ACC, oe_lo, ACC);
      chk("R3 strobe idle in read", we_lo == 0, we_lo, 0);
      chk("R4 valid pulse", rsp_valid == 1'b1, int'(rsp_valid), 1);
      chk("R4 read byte", rsp_rdata == d, int'(rsp_rdata), int'(d));
    end
  endtask

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    chk("R1 reset select", mem_cs_n && mem_we_n && mem_oe_n, int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
    chk("R1 reset drive", !mem_dq_oe && !rsp_valid, int'({mem_dq_oe, rsp_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", req_ready && mem_cs_n && !mem_dq_oe,
        int'({req_ready, mem_cs_n, mem_dq_oe}), 6);
    // Write with a request poked mid-access (R2).
    run_op(1'b1, 17'h00000, pat(17'h00000), 1'b1);
    for (int i = 1; i < 32; i++) begin
      a = AW'(i);
      run_op(1'b1, a, pat(a), 1'b0);
    end
    for (int i = 0; i < 32; i++) begin
      a = 17'h1FFE0 + AW'(i);
      run_op(1'b1, a, pat(a), 1'b0);
    end
    for (int i = 0; i < 32; i++) begin
      a = AW'(i);
      run_op(1'b0, a, pat(a), 1'b0);
      a = 17'h1FFE0 + AW'(i);
      run_op(1'b0, a, pat(a), 1'b0);
    end
    // Write then immediate read of the same byte, back to back (R10).
    run_op(1'b1, 17'h1FFFF, 8'h3C, 1'b0);
    run_op(1'b0, 17'h1FFFF, 8'h3C, 1'b0);
    @(negedge clk);
    chk("R4 valid lasts one cycle", rsp_valid == 1'b0, int'(rsp_valid), 0);
    chk("R4 byte held", rsp_rdata == 8'h3C, int'(rsp_rdata), 8'h3C);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule